// File: doc/BRIEF.md
# Aligned Multi-Output Clock Divider Bank

This block derives three divided clocks from one fast source clock. Each output has its own integer divider, programmed through a small register port. Software writes a new ratio code into an output's divider register. The code is held there as a pending value and changes nothing until a GO command is written.

On GO, each output that has a pending change and is not marked for alignment restarts at once with its new ratio. Outputs marked for alignment are handled together. Each running aligned output finishes its present period and then waits with its output low. When all of them are ready, every aligned counter reloads on one common source edge, so they rise together. A busy bit covers that wait.

Register map (address, use): 0..2 divider registers for outputs 0..2; 3 alignment register; 4 command on write and status on read.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset the divider registers read 16'h8002, 16'h8004 and 16'h803F (enable bit 15 set; ratio codes 02h, 04h, 3Fh). The alignment register reads 16'h0092 (bits 1, 4, 7 for outputs 0, 1, 2). The status register reads 0.
- R2: An active ratio code k in 01h..4Fh makes the output repeat every N = k+1 source cycles. Within each period the output is high for floor(N/2) cycles and low for the rest, so even ratios give a 50% duty cycle.
- R3: Code 00h (divide by 1) makes the output follow the source clock while the output is enabled.
- R4: When divider register bit 15 is 0, that output stays low. Clearing or setting bit 15 takes effect without a GO. The output restarts at the start of its period once it is enabled again.
- R5: A written ratio field (bits 7:0) above 4Fh is stored and read back as 4Fh, which divides by 80.
- R6: Reserved bits read as 0, and writes to them are ignored. These are bits 14:8 of a divider register, and every bit of the alignment register other than 1, 4 and 7.
- R7: A write to a divider register stores the new code, which is visible on read, and sets that output's pending flag (status bit 8+i). The output keeps its present ratio until a GO applies the code.
- R8: GO is a write of 1 to bit 0 at address 4. Each output with a pending flag and alignment bit 0 takes its new ratio on the GO edge, starting a fresh period high, and its flag clears. Busy (status bit 0) stays 0 when no aligned output is pending.
- R9: GO with a pending aligned output sets busy. Each running aligned output completes its period and then holds low. All aligned counters reload on one common edge, after which the aligned outputs rise together, busy clears and the aligned pending flags clear.
- R10: A GO written while busy is 1 is ignored. Pending flags of unaligned outputs stay set until a later GO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for addr (combinational) |
| clk_out | output | 3 | Divided clock outputs |
| busy | output | 1 | Aligned GO in progress |

## Verification
Every output is driven through every legal code from 01h to 4Fh with alignment off, and the high time and period are measured. This separates off-by-one errors in the divide count from errors in the duty split on odd ratios. Divide-by-1, a disabled output and an over-range code are each tried on their own. A mixed sequence runs the staging and GO paths: a write without GO, an immediate GO, and an aligned GO against a long-running ÷80 neighbour. The aligned case checks the common rising edge after busy falls. The long neighbour also gives time to show that a GO issued mid-alignment is dropped.

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int NOUT = 3,
  parameter int AW = 3,
  parameter logic [7:0] MAX_CODE = 8'h4F,
  parameter logic [NOUT*8-1:0] RST_CODE = 24'h3F_04_02
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [15:0]     wdata,
  output logic [15:0]     rdata,
  output logic [NOUT-1:0] clk_out,
  output logic            busy
);
  localparam logic [AW-1:0] ALN_ADDR = AW'(NOUT);
  localparam logic [AW-1:0] CMD_ADDR = AW'(NOUT + 1);

  logic [NOUT-1:0]       en, aln, flag, o_r, o_n;
  logic [NOUT-1:0]       term, ready, wr_div, imm;
  logic [NOUT-1:0][7:0]  pend, act, cnt, act_n, cnt_n, half_n;
  logic                  busy_r, rel, go, wr_aln, start_busy;
  logic [7:0]            wcode;
  logic                  unused_bits;

  assign unused_bits = ^wdata;
  assign busy   = busy_r;
  assign wr_aln = wr_en && addr == ALN_ADDR;
  assign go     = wr_en && addr == CMD_ADDR && wdata[0] && !busy_r;
  assign wcode  = (wdata[7:0] > MAX_CODE) ? MAX_CODE : wdata[7:0];

  always_comb begin
    for (int i = 0; i < NOUT; i++) begin
      wr_div[i] = wr_en && addr == AW'(i);
      term[i]   = cnt[i] == act[i];
      ready[i]  = !aln[i] || !en[i] || term[i];
      imm[i]    = go && flag[i] && !aln[i];
    end
  end

  assign rel        = busy_r && (&ready);
  assign start_busy = go && |(flag & aln);

  always_comb begin
    for (int i = 0; i < NOUT; i++) begin
      act_n[i] = act[i];
      cnt_n[i] = term[i] ? 8'd0 : cnt[i] + 8'd1;
      if (busy_r && aln[i] && term[i]) cnt_n[i] = cnt[i];
      if (rel && aln[i]) begin
        cnt_n[i] = 8'd0;
        if (flag[i]) act_n[i] = pend[i];
      end
      if (imm[i]) begin
        cnt_n[i] = 8'd0;
        act_n[i] = pend[i];
      end
      if (!en[i]) cnt_n[i] = 8'd0;
      half_n[i] = 8'(({1'b0, act_n[i]} + 9'd1) >> 1);
      o_n[i]    = cnt_n[i] < half_n[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '1;
      aln    <= '1;
      flag   <= '0;
      o_r    <= '1;
      busy_r <= 1'b0;
      cnt    <= '0;
      for (int i = 0; i < NOUT; i++) begin
        pend[i] <= RST_CODE[8*i +: 8];
        act[i]  <= RST_CODE[8*i +: 8];
      end
    end else begin
      cnt <= cnt_n;
      act <= act_n;
      o_r <= o_n;
      for (int i = 0; i < NOUT; i++) begin
        if ((rel && aln[i]) || imm[i]) flag[i] <= 1'b0;
        if (wr_div[i]) begin
          flag[i] <= 1'b1;
          pend[i] <= wcode;
          en[i]   <= wdata[15];
        end
        if (wr_aln) aln[i] <= wdata[1 + 3*i];
      end
      if (start_busy) busy_r <= 1'b1;
      else if (rel)   busy_r <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NOUT; i++) begin
      if (addr == AW'(i)) rdata = {en[i], 7'd0, pend[i]};
    end
    if (addr == ALN_ADDR)
      for (int i = 0; i < NOUT; i++) rdata[1 + 3*i] = aln[i];
    if (addr == CMD_ADDR) begin
      rdata[0] = busy_r;
      for (int i = 0; i < NOUT; i++) rdata[8 + i] = flag[i];
    end
  end

  generate
    for (genvar g = 0; g < NOUT; g++) begin : g_out
      assign clk_out[g] = en[g] & ((act[g] == 8'd0) ? clk : o_r[g]);
    end
  endgenerate
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NOUT = 3,
  parameter int AW = 3,
  parameter logic [7:0] MAX_CODE = 8'h4F
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [AW-1:0]        addr,
  input logic [15:0]          wdata,
  input logic [15:0]          rdata,
  input logic                 busy,
  input logic [NOUT-1:0]      clk_out,
  input logic [NOUT-1:0]      en,
  input logic [NOUT-1:0]      aln,
  input logic [NOUT-1:0][7:0] act,
  input logic [NOUT-1:0]      o_r
);
  localparam logic [AW-1:0] CMD_ADDR = AW'(NOUT + 1);
  logic [NOUT-1:0] nz;

  always_comb
    for (int i = 0; i < NOUT; i++) nz[i] = act[i] != 8'd0;

  generate
    for (genvar g = 0; g < NOUT; g++) begin : g_chk
      // R5
      code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act[g] <= MAX_CODE);
      // R4
      disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[g] |-> !clk_out[g]);
    end
  endgenerate

  // R9
  aligned_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> &(o_r | ~(aln & en & nz)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == CMD_ADDR && wdata[0]));

  // R6
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < AW'(NOUT)) |-> rdata[14:8] == 7'd0);
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NOUT(NOUT), .AW(AW), .MAX_CODE(MAX_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .busy(busy), .clk_out(clk_out), .en(en), .aln(aln),
  .act(act), .o_r(o_r)
);

// File: tb/sim_clkdiv_bank.sv
`timescale 1ns/1ps
module sim_clkdiv_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [2:0]  clk_out;
  logic        busy;
  int n_chk = 0, n_fail = 0;

  clkdiv_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_out(clk_out), .busy(busy));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int actual, input int expect_v);
    n_chk++;
    if (actual != expect_v) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, actual, expect_v);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = 3'(a); #1 d = int'(rdata);
  endtask

  task automatic measure(input int i, output int hi, output int per);
    logic p;
    int guard;
    p = clk_out[i];
    guard = 0;
    do begin
      @(negedge clk); guard++;
      if (clk_out[i] && !p) break;
      p = clk_out[i];
    end while (guard < 400);
    hi = 1; per = 1; p = 1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (clk_out[i] && !p) break;
      if (clk_out[i]) hi++;
      per++;
      p = clk_out[i];
    end
  endtask

  initial begin
    #1_400_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d, hi, per, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, d); chk("R1 div0", d, 'h8002);
    rd(1, d); chk("R1 div1", d, 'h8004);
    rd(2, d); chk("R1 div2", d, 'h803F);
    rd(3, d); chk("R1 align", d, 'h0092);
    rd(4, d); chk("R1 status", d, 0);
    measure(1, hi, per);
    chk("R2 reset div1 period", per, 5); chk("R2 reset div1 high", hi, 2);
    // R5 R6 clamp and reserved bits
    wr(2, 'hFFFF); rd(2, d); chk("R5 R6 div2 readback", d, 'h804F);
    rd(4, d); chk("R7 flag2", d, 'h0400);
    wr(3, 'hFFFF); rd(3, d); chk("R6 align readback", d, 'h0092);
    wr(3, 0); rd(3, d); chk("R6 align cleared", d, 0);
    wr(2, 'h803F);
    // R7 staged write
    wr(1, 'h8009); rd(1, d); chk("R7 div1 readback", d, 'h8009);
    rd(4, d); chk("R7 flags", d, 'h0600);
    measure(1, hi, per); chk("R7 old ratio kept", per, 5);
    // R8 immediate GO
    wr(4, 1);
    chk("R8 restart high", int'(clk_out[1]), 1);
    chk("R8 busy low", int'(busy), 0);
    rd(4, d); chk("R8 flags cleared", d, 0);
    measure(1, hi, per); chk("R8 new period", per, 10);
    // R2 sweep of all legal codes on every output
    for (int i = 0; i < 3; i++) begin
      for (int c = 1; c <= 'h4F; c++) begin
        wr(i, 'h8000 | c); wr(4, 1);
        measure(i, hi, per);
        chk($sformatf("R2 out%0d code %0h period", i, c), per, c + 1);
        chk($sformatf("R2 out%0d code %0h high", i, c), hi, (c + 1) / 2);
      end
    end
    // R3 divide by one
    wr(0, 'h8000); wr(4, 1);
    w = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #2 if (clk_out[0] !== 1'b1) w++;
      @(negedge clk); #2 if (clk_out[0] !== 1'b0) w++;
    end
    chk("R3 passthrough mismatches", w, 0);
    // R4 disable
    wr(0, 'h0007); rd(0, d); chk("R4 disabled readback", d, 'h0007);
    w = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #2 if (clk_out[0] !== 1'b0) w++;
      @(negedge clk); #2 if (clk_out[0] !== 1'b0) w++;
    end
    chk("R4 disabled stays low", w, 0);
    wr(0, 'h8007); wr(4, 1);
    measure(0, hi, per); chk("R4 reenabled period", per, 8);
    // R5 clamp in effect
    wr(0, 'h80C8); rd(0, d); chk("R5 clamp readback", d, 'h804F);
    wr(4, 1); measure(0, hi, per); chk("R5 clamp period", per, 80);
    // R9 aligned GO against a running /80 on output 2
    wr(3, 'h0092); wr(0, 'h8003); wr(1, 'h8009); wr(4, 1);
    chk("R9 busy after GO", int'(busy), 1);
    w = 0;
    while (busy && w < 500) begin @(negedge clk); w++; end
    chk("R9 busy ended", int'(busy), 0);
    chk("R9 common rise", int'(clk_out), 'b111);
    // R10 GO during busy is dropped
    wr(3, 'h0090); wr(1, 'h8004); wr(4, 1);
    chk("R10 busy set", int'(busy), 1);
    wr(0, 'h8002); wr(4, 1);
    rd(4, d); chk("R10 flag0 kept during busy", (d >> 8) & 1, 1);
    w = 0;
    while (busy && w < 500) begin @(negedge clk); w++; end
    chk("R9 aligned pair rise", int'(clk_out[2:1]), 'b11);
    rd(4, d); chk("R10 flag0 kept after busy", d, 'h0100);
    wr(4, 1);
    chk("R8 out0 restart", int'(clk_out[0]), 1);
    rd(4, d); chk("R9 R8 flags clear", d, 0);
    measure(0, hi, per); chk("R8 out0 period", per, 3);
    measure(1, hi, per); chk("R9 out1 period", per, 5);
    measure(2, hi, per); chk("R9 out2 period", per, 80);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule